// File: doc/BRIEF.md
# Audio Codec Power-Up Sequencer

This block sits on the host side of an audio converter and walks it from reset to normal playback. It keeps the converter's reset line low until the supply and clock monitors both report good, then releases it. Over a simple valid/ready register-write channel it puts the converter into power-down, loads a small configuration table, and then takes power-down away again. A downstream serializer turns each accepted write into control-bus traffic.

The DAC mute output is high from reset and through the whole configuration. It stays high while the converter's reference ramps up, a period measured in audio frame-clock (LRCK) cycles. LRCK enters through a two-flop synchronizer and only its rising edges are counted. Mute is released and the ready flag is raised only after the initialization count and then the settling count have both completed. If the supply indication drops at any time, the sequence goes back to the reset-hold state.

Top module: `codec_bringup_seq`

## Requirements
- R1: While `rst_n` is low, or while `supply_ok` and `clocks_ok` are not both high in the hold state, `codec_rst_n` is 0, `mute` is 1, `ready` is 0 and `wr_valid` is 0.
- R2: The first write after `codec_rst_n` rises is presented in that same cycle. It targets address 02h with data 01h, so bit 0 is the power-down bit and it is set to 1.
- R3: Next come NUM_CFG table writes in order k = 0, 1, ... Write k goes to address 03h+k with data (37*k+5) mod 256. No write to address 02h occurs among them, so power-down stays set while they load.
- R4: The last write clears power-down: address 02h, data 00h. Every write, including this one, is accepted while `mute` is 1.
- R5: `wr_valid` is held with a stable `wr_addr` and `wr_data` until `wr_ready` is high. Each item is accepted exactly once, and the sequence moves to the next item only on acceptance.
- R6: After the power-down clear is accepted, `mute` stays 1 and `ready` stays 0 for INIT_FRAMES + SETTLE_FRAMES rising LRCK edges (2000 + 90 by default). Within three clocks of the last of those edges, `mute` falls and `ready` rises in the same cycle.
- R7: When `supply_ok` is sampled low in any state, on the following cycle `codec_rst_n` is 0, `mute` is 1, `ready` is 0 and `wr_valid` is 0. When the conditions return, the sequence restarts from R2.
- R8: In normal operation `ready` stays 1 and no further writes are issued until the supply is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer |
| supply_ok | input | 1 | Supply within operating range |
| clocks_ok | input | 1 | Converter clocks stable |
| lrck | input | 1 | Audio frame clock, asynchronous to clk |
| codec_rst_n | output | 1 | Active-low reset to the converter |
| wr_addr | output | AW | Register write address |
| wr_data | output | DW | Register write data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Downstream accepts the write |
| mute | output | 1 | DAC mute, high = muted |
| ready | output | 1 | Converter in normal operation |

## Verification
On every cycle the assertions check the following: reset is held while the supply and clocks are not good, the first write after release is the power-down set, a pending write keeps its address and data stable, the power-down clear is only issued with mute high, mute and ready change together, and supply loss returns the block to the hold state. The bench scenarios cover what the assertions cannot. The scoreboard confirms the exact order and contents of the write sequence under backpressure. The bench also counts the exact number of frame edges between the power-down clear and the unmute. It checks that a supply drop in the middle of configuration leads to a clean, complete restart, and that the block stays in normal operation with no further writes.

// File: rtl/codec_bringup_seq.sv
module codec_bringup_seq #(
  parameter int AW            = 8,
  parameter int DW            = 8,
  parameter int PWR_ADDR      = 8'h02,
  parameter int CFG_BASE      = 8'h03,
  parameter int NUM_CFG       = 6,
  parameter int INIT_FRAMES   = 2000,
  parameter int SETTLE_FRAMES = 90
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          clocks_ok,
  input  logic          lrck,
  output logic          codec_rst_n,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic          mute,
  output logic          ready
);

  localparam int MAXF = (INIT_FRAMES > SETTLE_FRAMES) ? INIT_FRAMES : SETTLE_FRAMES;
  localparam int CW   = $clog2(MAXF + 1);
  localparam int IW   = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

  typedef enum logic [2:0] {
    S_HOLD, S_PDN_SET, S_LOAD, S_PDN_CLR, S_INIT, S_SETTLE, S_RUN
  } state_t;

  state_t          st;
  logic [IW-1:0]   idx;
  logic [CW-1:0]   cnt;
  logic [2:0]      lr_sync;
  logic            lr_rise;

  function automatic logic [DW-1:0] cfg_word(input logic [IW-1:0] k);
    return DW'(32'd37 * 32'(k) + 32'd5);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lr_sync <= '0;
    else        lr_sync <= {lr_sync[1:0], lrck};

  assign lr_rise = lr_sync[1] & ~lr_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_HOLD;
      idx <= '0;
      cnt <= '0;
    end else if (!supply_ok) begin
      st  <= S_HOLD;
      idx <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_HOLD:    if (clocks_ok) st <= S_PDN_SET;
        S_PDN_SET: if (wr_ready) begin
          st  <= S_LOAD;
          idx <= '0;
        end
        S_LOAD:    if (wr_ready) begin
          if (idx == IW'(NUM_CFG - 1)) st <= S_PDN_CLR;
          else                         idx <= idx + 1'b1;
        end
        S_PDN_CLR: if (wr_ready) begin
          st  <= S_INIT;
          cnt <= '0;
        end
        S_INIT:    if (lr_rise) begin
          if (cnt == CW'(INIT_FRAMES - 1)) begin
            st  <= S_SETTLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_SETTLE:  if (lr_rise) begin
          if (cnt == CW'(SETTLE_FRAMES - 1)) begin
            st  <= S_RUN;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_RUN:     st <= S_RUN;
        default:   st <= S_HOLD;
      endcase
    end
  end

  assign codec_rst_n = (st != S_HOLD);
  assign mute        = (st != S_RUN);
  assign ready       = (st == S_RUN);
  assign wr_valid    = supply_ok &&
                       (st == S_PDN_SET || st == S_LOAD || st == S_PDN_CLR);

  always_comb begin
    wr_addr = AW'(PWR_ADDR);
    wr_data = '0;
    case (st)
      S_PDN_SET: wr_data = DW'(1);
      S_LOAD: begin
        wr_addr = AW'(CFG_BASE) + AW'(idx);
        wr_data = cfg_word(idx);
      end
      default: ;
    endcase
  end

  a_r1_hold_until_good: assert property (@(posedge clk) disable iff (!rst_n)
    (!codec_rst_n && !(supply_ok && clocks_ok)) |=> !codec_rst_n);

  a_r2_first_write_pdn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codec_rst_n) |-> (wr_valid && wr_addr == AW'(PWR_ADDR) && wr_data[0]));

  a_r4_clear_while_muted: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == AW'(PWR_ADDR) && !wr_data[0]) |-> mute);

  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=>
      (!supply_ok || (wr_valid && $stable(wr_addr) && $stable(wr_data))));

  a_r6_unmute_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> (ready && codec_rst_n && !wr_valid));

  a_r7_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!codec_rst_n && mute && !ready && !wr_valid));

  a_r8_stay_running: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && supply_ok) |=> (ready && !wr_valid));

endmodule

// File: tb/sim_codec_bringup_seq.sv
module sim_codec_bringup_seq;
  localparam int NCFG = 6;
  localparam int FRAMES = 2000 + 90;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n, supply_ok, clocks_ok, lrck, wr_ready;
  logic codec_rst_n, wr_valid, mute, ready;
  logic [7:0] wr_addr, wr_data;

  codec_bringup_seq u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .clocks_ok(clocks_ok),
    .lrck(lrck), .codec_rst_n(codec_rst_n), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .mute(mute), .ready(ready)
  );

  int checks = 0, fails = 0;
  logic [15:0] expq[$];
  int pops = 0;
  bit pd_clear_seen = 0;
  bit stall = 0;
  bit lrck_run = 0;
  int rises = 0;
  int ph = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_seq();
    expq.push_back({8'h02, 8'h01});
    for (int k = 0; k < NCFG; k++)
      expq.push_back({8'(8'h03 + k), 8'(37 * k + 5)});
    expq.push_back({8'h02, 8'h00});
  endtask

  initial lrck = 0;
  always @(negedge clk) begin
    if (lrck_run) begin
      ph++;
      if (ph == 8) begin
        ph = 0;
        if (!lrck) rises++;
        lrck <= ~lrck;
      end
    end else begin
      ph = 0;
      lrck <= 0;
    end
  end

  initial wr_ready = 0;
  always @(negedge clk) begin
    cyc++;
    wr_ready <= stall ? (cyc % 3 == 0) : 1'b1;
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && wr_valid && wr_ready) begin
      pops++;
      chk(mute == 1'b1, "R4", "mute during write", int'(mute), 1);
      if (expq.size() == 0) begin
        chk(0, "R5", "unexpected write addr", int'(wr_addr), -1);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(wr_addr == e[15:8], "R3", "write addr", int'(wr_addr), int'(e[15:8]));
        chk(wr_data == e[7:0], "R3", "write data", int'(wr_data), int'(e[7:0]));
        if (e == 16'h0200) pd_clear_seen = 1;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int p0;
    rst_n = 0; supply_ok = 0; clocks_ok = 0;
    repeat (5) @(negedge clk);
    #2;
    chk(codec_rst_n == 0, "R1", "codec_rst_n in reset", int'(codec_rst_n), 0);
    chk(mute == 1 && ready == 0 && wr_valid == 0, "R1", "mute/ready/valid in reset",
        int'({mute, ready, wr_valid}), 4);
    @(negedge clk);
    rst_n = 1; supply_ok = 1;
    repeat (20) @(negedge clk);
    #2;
    chk(codec_rst_n == 0 && wr_valid == 0, "R1", "held without clocks_ok",
        int'({codec_rst_n, wr_valid}), 0);

    push_seq();
    stall = 1;
    pd_clear_seen = 0;
    @(negedge clk);
    clocks_ok = 1;
    @(negedge clk);
    #1;
    chk(codec_rst_n == 1 && wr_valid == 1, "R2", "release with first request",
        int'({codec_rst_n, wr_valid}), 3);
    chk(wr_addr == 8'h02 && wr_data == 8'h01, "R2", "first write addr/data",
        int'({wr_addr, wr_data}), 16'h0201);
    wait (pd_clear_seen);
    repeat (4) @(negedge clk);
    rises = 0;
    lrck_run = 1;
    wait (rises == 2060);
    @(negedge clk); #2;
    chk(mute == 1 && ready == 0, "R6", "still muted mid-ramp", int'({mute, ready}), 2);
    wait (ready == 1);
    @(negedge clk); #2;
    chk(rises == FRAMES, "R6", "frame edges before unmute", rises, FRAMES);
    chk(mute == 0, "R6", "mute released with ready", int'(mute), 0);
    chk(expq.size() == 0, "R3", "all writes issued", expq.size(), 0);

    p0 = pops;
    repeat (100) @(negedge clk);
    #2;
    chk(ready == 1 && mute == 0, "R8", "stays in normal operation", int'({ready, mute}), 2);
    chk(pops == p0, "R8", "no writes while running", pops - p0, 0);

    @(negedge clk);
    supply_ok = 0;
    @(negedge clk); #2;
    chk(codec_rst_n == 0 && mute == 1 && ready == 0, "R7", "supply loss in run",
        int'({codec_rst_n, mute, ready}), 2);
    lrck_run = 0;

    repeat (5) @(negedge clk);
    push_seq();
    stall = 1;
    pops = 0;
    @(negedge clk);
    supply_ok = 1;
    wait (pops == 3);
    @(negedge clk);
    supply_ok = 0;
    expq.delete();
    @(negedge clk); #2;
    chk(codec_rst_n == 0 && wr_valid == 0 && mute == 1, "R7", "supply loss mid-load",
        int'({codec_rst_n, wr_valid, mute}), 1);

    repeat (5) @(negedge clk);
    push_seq();
    stall = 0;
    pd_clear_seen = 0;
    @(negedge clk);
    supply_ok = 1;
    wait (pd_clear_seen);
    repeat (4) @(negedge clk);
    rises = 0;
    lrck_run = 1;
    wait (ready == 1);
    @(negedge clk); #2;
    chk(rises == FRAMES, "R6", "frame edges after restart", rises, FRAMES);
    chk(expq.size() == 0, "R7", "full restart sequence issued", expq.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule